// File: doc/BRIEF.md
# Operation-Period Bank Sequencer

This block is the control sequencer for a double-buffered multiply-accumulate engine. It keeps no data. It counts issued operations and, for the next operation, tells the engine four things: which weight bank to read, which accumulator bank to write, whether to overwrite the accumulator or add to it, and which accumulator bank the output transfer path should read. Each of these follows its own programmed period, counted in operations.

A typical setup covers a reduction over K input groups of N channels. The weight bank period is N. The overwrite op runs for N operations and the accumulate op runs for (K-1)·N operations. The accumulator write bank and the readout bank both switch every K·N operations. The readout bank starts on the bank opposite to the first write bank. Each time an accumulator bank is finished, the block raises a one-cycle transfer-ready pulse and reports which bank completed, so the output path can drain it while the engine fills the other bank.

A synchronous open pulse loads the start bits and clears every counter. After that, each `op_fire` strobe advances the sequencer by one operation.

Top module: `op_bank_sequencer`

## Requirements
- R1: After `rst_n` is released, `wt_bank`, `acc_wr_bank` and `acc_rd_bank` are 0, `op_sel` is 0 and `xfer_ready` is 0.
- R2: A cycle with `open_pulse` high loads `wt_bank`=`wt_start`, `op_sel`=`op_start`, `acc_wr_bank`=0 and `acc_rd_bank`=`rd_start`, clears every operation counter and drives `xfer_ready` low. It takes precedence over an `op_fire` in the same cycle.
- R3: With `wt_period`=P>0, `wt_bank` inverts after every P-th `op_fire` counted from the last open.
- R4: `op_sel` (0 = overwrite op, 1 = accumulate op) stays at its current value for that op's length in fires (`op0_len` or `op1_len`) and then changes to the other op. The pattern repeats.
- R5: With `acc_wr_period`=P>0, `acc_wr_bank` inverts after every P-th `op_fire`.
- R6: `xfer_ready` is high for exactly the cycle after a fire that inverts `acc_wr_bank`. In that cycle `xfer_bank` equals the bank that was just completed, which is the inverse of the new `acc_wr_bank`.
- R7: With `rd_period`=P>0, `acc_rd_bank` inverts after every P-th `op_fire`, independently of the write bank.
- R8: A period of zero means the related bank never switches. If the current op's length is zero, `op_sel` never leaves that op. If the other op's length is zero, `op_sel` returns to the current op at the end of each run instead of switching.
- R9: Without `op_fire` and `open_pulse`, no output changes, and `xfer_ready` is low.
- R10: All outputs are registered. Each update is visible in the cycle after the clock edge that samples `op_fire` or `open_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| open_pulse | input | 1 | Load start bits and clear counters |
| op_fire | input | 1 | One operation issued |
| wt_period | input | CNT_W | Weight bank switch period (ops) |
| op0_len | input | CNT_W | Length of the overwrite-op run (ops) |
| op1_len | input | CNT_W | Length of the accumulate-op run (ops) |
| acc_wr_period | input | CNT_W | Accumulator write bank switch period (ops) |
| rd_period | input | CNT_W | Readout bank switch period (ops) |
| wt_start | input | 1 | Weight bank after open |
| op_start | input | 1 | Op after open |
| rd_start | input | 1 | Readout bank after open |
| wt_bank | output | 1 | Weight bank for the next op |
| op_sel | output | 1 | Op code for the next op |
| acc_wr_bank | output | 1 | Accumulator bank written by the next op |
| acc_rd_bank | output | 1 | Accumulator bank read by the transfer path |
| xfer_ready | output | 1 | Accumulator bank completed pulse |
| xfer_bank | output | 1 | The bank that was just completed |

## Verification
Every output is one register stage behind the edge that samples `op_fire` or `open_pulse`. The bench therefore drives stimulus on the falling edge and advances a behavioural model on the rising edge. On the next falling edge it compares all six outputs with the model, so each result is checked in the first cycle it is due. The `xfer_ready` pulse is due in the single cycle after the completing fire, and it is compared as low in every other cycle. Directed checks cover idle gaps, zero periods, a period of one, an open that coincides with a fire, and an accumulate length of zero.

// File: rtl/seq_pkg.sv
package seq_pkg;
   typedef enum logic {
      OP_OVERWRITE  = 1'b0,
      OP_ACCUMULATE = 1'b1
   } op_code_e;

   // bank channels driven by period counters
   localparam int unsigned CH_WEIGHT = 0;
   localparam int unsigned CH_ACC_WR = 1;
   localparam int unsigned CH_ACC_RD = 2;
   localparam int unsigned NUM_CH    = 3;
endpackage

// File: rtl/seq_period_tick.sv
module seq_period_tick #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             adv,
   input  logic [CNT_W-1:0] period,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt;
   logic             per_zero;
   logic             at_end;

   assign per_zero = (period == '0);
   assign at_end   = !per_zero && (cnt >= period - ONE);
   assign wrap     = adv && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt <= '0;
      end else if (adv && !per_zero) begin
         if (at_end) cnt <= '0;
         else        cnt <= cnt + ONE;
      end
   end

   // zero period: counter frozen (R8)
   assert_zero_period_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && per_zero) |=> $stable(cnt));
   // no advance, no count change (R9)
   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !adv) |=> $stable(cnt));
endmodule

// File: rtl/seq_bank_reg.sv
module seq_bank_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic load_val,
   input  logic toggle,
   output logic bank
);
   always_ff @(posedge clk) begin
      if (!rst_n)      bank <= 1'b0;
      else if (load)   bank <= load_val;
      else if (toggle) bank <= ~bank;
   end

   assert_toggle_flips_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && toggle) |=> (bank != $past(bank)));
   assert_bank_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !toggle) |=> $stable(bank));
   assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (bank == $past(load_val)));
endmodule

// File: rtl/seq_op_select.sv
module seq_op_select
   import seq_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_pulse,
   input  logic             op_start,
   input  logic             fire,
   input  logic [CNT_W-1:0] len0,
   input  logic [CNT_W-1:0] len1,
   output op_code_e         op
);
   logic [CNT_W-1:0] cur_len;
   logic [CNT_W-1:0] next_len;
   logic             run_done;

   assign cur_len  = (op == OP_ACCUMULATE) ? len1 : len0;
   assign next_len = (op == OP_ACCUMULATE) ? len0 : len1;

   seq_period_tick #(.CNT_W(CNT_W)) u_run_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (open_pulse),
      .adv    (fire),
      .period (cur_len),
      .wrap   (run_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         op <= OP_OVERWRITE;
      else if (open_pulse)
         op <= op_code_e'(op_start);
      else if (run_done && next_len != '0)
         op <= (op == OP_ACCUMULATE) ? OP_OVERWRITE : OP_ACCUMULATE;
   end

   assert_op_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_pulse && !fire) |=> $stable(op));
   assert_op_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_pulse && cur_len == '0) |=> $stable(op));
   assert_op_no_empty_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_pulse && next_len == '0) |=> $stable(op));
endmodule

// File: rtl/op_bank_sequencer.sv
module op_bank_sequencer
   import seq_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_pulse,
   input  logic             op_fire,
   input  logic [CNT_W-1:0] wt_period,
   input  logic [CNT_W-1:0] op0_len,
   input  logic [CNT_W-1:0] op1_len,
   input  logic [CNT_W-1:0] acc_wr_period,
   input  logic [CNT_W-1:0] rd_period,
   input  logic             wt_start,
   input  logic             op_start,
   input  logic             rd_start,
   output logic             wt_bank,
   output logic             op_sel,
   output logic             acc_wr_bank,
   output logic             acc_rd_bank,
   output logic             xfer_ready,
   output logic             xfer_bank
);
   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_width
         $error("op_bank_sequencer: CNT_W must lie in 2..64");
      end
   endgenerate

   logic [CNT_W-1:0] ch_period [NUM_CH];
   logic             ch_init   [NUM_CH];
   logic             ch_wrap   [NUM_CH];
   logic             ch_bank   [NUM_CH];
   op_code_e         op_q;

   assign ch_period[CH_WEIGHT] = wt_period;
   assign ch_period[CH_ACC_WR] = acc_wr_period;
   assign ch_period[CH_ACC_RD] = rd_period;
   assign ch_init[CH_WEIGHT]   = wt_start;
   assign ch_init[CH_ACC_WR]   = 1'b0;
   assign ch_init[CH_ACC_RD]   = rd_start;

   genvar g;
   generate
      for (g = 0; g < NUM_CH; g++) begin : g_ch
         seq_period_tick #(.CNT_W(CNT_W)) u_tick (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (open_pulse),
            .adv    (op_fire),
            .period (ch_period[g]),
            .wrap   (ch_wrap[g])
         );
         seq_bank_reg u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (open_pulse),
            .load_val (ch_init[g]),
            .toggle   (ch_wrap[g]),
            .bank     (ch_bank[g])
         );
      end
   endgenerate

   seq_op_select #(.CNT_W(CNT_W)) u_op (
      .clk        (clk),
      .rst_n      (rst_n),
      .open_pulse (open_pulse),
      .op_start   (op_start),
      .fire       (op_fire),
      .len0       (op0_len),
      .len1       (op1_len),
      .op         (op_q)
   );

   // completion pulse, registered alongside the bank switch
   always_ff @(posedge clk) begin
      if (!rst_n || open_pulse) begin
         xfer_ready <= 1'b0;
         xfer_bank  <= 1'b0;
      end else begin
         xfer_ready <= ch_wrap[CH_ACC_WR];
         if (ch_wrap[CH_ACC_WR]) xfer_bank <= ch_bank[CH_ACC_WR];
      end
   end

   assign wt_bank     = ch_bank[CH_WEIGHT];
   assign acc_wr_bank = ch_bank[CH_ACC_WR];
   assign acc_rd_bank = ch_bank[CH_ACC_RD];
   assign op_sel      = op_q;

   assert_xfer_opposite_R6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ready |-> (xfer_bank != acc_wr_bank));
   assert_xfer_on_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ready |-> (acc_wr_bank != $past(acc_wr_bank)));
   assert_xfer_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_fire && !open_pulse) |=> !xfer_ready);
   assert_open_wr_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
      open_pulse |=> (!acc_wr_bank && !xfer_ready));
endmodule

// File: tb/op_bank_sequencer_tb_top.sv
module op_bank_sequencer_tb_top;
   localparam int CW = 32;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;   // 200 MHz

   logic          rst_n = 1'b0;
   logic          open_pulse = 1'b0, op_fire = 1'b0;
   logic [CW-1:0] wt_period = '0, op0_len = '0, op1_len = '0;
   logic [CW-1:0] acc_wr_period = '0, rd_period = '0;
   logic          wt_start = 1'b0, op_start = 1'b0, rd_start = 1'b0;
   logic wt_bank, op_sel, acc_wr_bank, acc_rd_bank, xfer_ready, xfer_bank;

   op_bank_sequencer #(.CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .open_pulse(open_pulse), .op_fire(op_fire),
      .wt_period(wt_period), .op0_len(op0_len), .op1_len(op1_len),
      .acc_wr_period(acc_wr_period), .rd_period(rd_period),
      .wt_start(wt_start), .op_start(op_start), .rd_start(rd_start),
      .wt_bank(wt_bank), .op_sel(op_sel), .acc_wr_bank(acc_wr_bank),
      .acc_rd_bank(acc_rd_bank), .xfer_ready(xfer_ready), .xfer_bank(xfer_bank));

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   // behavioural reference
   longint unsigned cw, co, ca, cr;
   bit m_wb, m_op, m_aw, m_ar, m_xr, m_xb;

   always @(posedge clk) begin
      if (!rst_n) begin
         cw = 0; co = 0; ca = 0; cr = 0;
         m_wb = 0; m_op = 0; m_aw = 0; m_ar = 0; m_xr = 0; m_xb = 0;
      end else if (open_pulse) begin
         cw = 0; co = 0; ca = 0; cr = 0;
         m_wb = wt_start; m_op = op_start; m_aw = 0; m_ar = rd_start;
         m_xr = 0; m_xb = 0;
      end else begin
         m_xr = 0;
         if (op_fire) begin
            if (wt_period != 0) begin
               cw++;
               if (cw >= wt_period) begin cw = 0; m_wb = !m_wb; end
            end
            if ((m_op ? op1_len : op0_len) != 0) begin
               co++;
               if (co >= (m_op ? op1_len : op0_len)) begin
                  co = 0;
                  if ((m_op ? op0_len : op1_len) != 0) m_op = !m_op;
               end
            end
            if (acc_wr_period != 0) begin
               ca++;
               if (ca >= acc_wr_period) begin
                  ca = 0; m_xr = 1; m_xb = m_aw; m_aw = !m_aw;
               end
            end
            if (rd_period != 0) begin
               cr++;
               if (cr >= rd_period) begin cr = 0; m_ar = !m_ar; end
            end
         end
      end
   end

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the active edge (R10)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3", "wt_bank", wt_bank, m_wb);
         chk("R4", "op_sel", op_sel, m_op);
         chk("R5", "acc_wr_bank", acc_wr_bank, m_aw);
         chk("R7", "acc_rd_bank", acc_rd_bank, m_ar);
         chk("R6", "xfer_ready", xfer_ready, m_xr);
         if (m_xr) chk("R6", "xfer_bank", xfer_bank, m_xb);
      end
   end

   task automatic open_cfg(input int wp, input int o0, input int o1, input int ap,
                           input int rp, input bit ws, input bit os, input bit rs);
      @(negedge clk);
      wt_period = wp; op0_len = o0; op1_len = o1; acc_wr_period = ap; rd_period = rp;
      wt_start = ws; op_start = os; rd_start = rs;
      open_pulse = 1'b1; op_fire = 1'b0;
      @(negedge clk);
      open_pulse = 1'b0;
   endtask

   task automatic fires(input int n, input int gap_mask);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         op_fire = 1'b1;
         if (((gap_mask >> (i % 8)) & 1) != 0) begin
            @(negedge clk);
            op_fire = 1'b0;
         end
      end
      @(negedge clk);
      op_fire = 1'b0;
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "wt_bank", wt_bank, 1'b0);
      chk("R1", "op_sel", op_sel, 1'b0);
      chk("R1", "acc_wr_bank", acc_wr_bank, 1'b0);
      chk("R1", "acc_rd_bank", acc_rd_bank, 1'b0);
      chk("R1", "xfer_ready", xfer_ready, 1'b0);

      // K=3 groups of N=4: R3 R4 R5 R6 R7, readout opposite
      open_cfg(4, 4, 8, 12, 12, 0, 0, 1);
      @(negedge clk);
      chk("R2", "acc_rd_bank", acc_rd_bank, 1'b1);
      chk("R2", "acc_wr_bank", acc_wr_bank, 1'b0);
      fires(60, 0);
      fires(40, 8'b0101_0011);

      // R9 idle: nothing moves
      begin
         logic s_wb, s_op, s_aw, s_ar;
         s_wb = wt_bank; s_op = op_sel; s_aw = acc_wr_bank; s_ar = acc_rd_bank;
         repeat (6) @(negedge clk);
         chk("R9", "wt_bank idle", wt_bank, s_wb);
         chk("R9", "op_sel idle", op_sel, s_op);
         chk("R9", "acc_wr_bank idle", acc_wr_bank, s_aw);
         chk("R9", "acc_rd_bank idle", acc_rd_bank, s_ar);
         chk("R9", "xfer_ready idle", xfer_ready, 1'b0);
      end

      // R2 start bits set, then open colliding with a fire
      open_cfg(3, 2, 5, 7, 5, 1, 1, 0);
      @(negedge clk);
      chk("R2", "wt_bank", wt_bank, 1'b1);
      chk("R2", "op_sel", op_sel, 1'b1);
      fires(5, 0);
      @(negedge clk);
      op_fire = 1'b1; open_pulse = 1'b1;
      @(negedge clk);
      op_fire = 1'b0; open_pulse = 1'b0;
      chk("R2", "wt_bank after open+fire", wt_bank, 1'b1);
      chk("R2", "xfer_ready after open+fire", xfer_ready, 1'b0);
      fires(50, 8'b0010_0100);

      // R8 zero periods, zero accumulate length
      open_cfg(0, 3, 0, 0, 0, 1, 0, 1);
      fires(20, 0);
      chk("R8", "wt_bank zero period", wt_bank, 1'b1);
      chk("R8", "acc_wr_bank zero period", acc_wr_bank, 1'b0);
      chk("R8", "acc_rd_bank zero period", acc_rd_bank, 1'b1);
      chk("R8", "op_sel stays overwrite", op_sel, 1'b0);
      open_cfg(2, 0, 4, 3, 0, 0, 0, 0);
      fires(10, 0);
      chk("R8", "op_sel zero-length current op", op_sel, 1'b0);

      // period one: switch on every fire, back-to-back pulses (R6)
      open_cfg(1, 1, 1, 1, 1, 0, 0, 1);
      fires(16, 0);
      fires(16, 8'b1010_1010);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule